// File: doc/BRIEF.md
# Latched Time-of-Day Event Counter

This block keeps a 24-bit count of tick events and makes it available to a processor as three byte-wide registers on a small register bus. The tick comes from one of two pins. One is a mains or power-supply tick, used on boards that have one. The other is the vertical-sync pulse, used on boards that do not. A static select input picks the pin. The chosen pin is synchronised and counted on its rising edges only.

Software reads a multi-byte value safely because of a snapshot latch. Reading the most significant byte freezes a copy of the whole count. Reads of the other bytes then return that frozen copy. Only a read of the least significant byte releases it. Writes load the count one byte at a time. Writing the most significant byte stops counting, and writing the least significant byte starts it again, so a load cannot be disturbed by a carry partway through. The usual clear sequence writes zero to the high byte, then the middle byte, then the low byte. Reads may be placed between those writes.

The register bus is plain and has no handshake. Every access with chip-select high completes in the cycle it is presented. Read data is combinational from the current address. There is no back-pressure: the block never stalls the bus.

Top module: `tod_event_counter`

## Requirements
- R1: After reset the count is zero, no snapshot is held and counting is enabled.
- R2: Register index 0 is the low byte (count bits 7:0), index 1 the middle byte (bits 15:8) and index 2 the high byte (bits 23:16). Index 3 reads as 0x00, and a write to index 3 changes nothing.
- R3: A read of index 2 while no snapshot is held captures the full live count. While the snapshot is held, reads of every index return bytes of the captured value, even if ticks arrive.
- R4: Only a read of index 0 releases a held snapshot. If the snapshot is never released, the first reads after a clear and a restart return the old pre-clear bytes.
- R5: A write to index 0 loads the low byte but does not release a held snapshot.
- R6: A write to indices 0 to 2 loads that byte of the count. Writing zero to index 2, then 1, then 0, with reads placed between the writes, leaves the count at zero.
- R7: A write to index 2 stops counting. Ticks are ignored until a write to index 0 restarts counting.
- R8: Each rising edge of the selected tick pin adds exactly one to the count. The edge passes through two synchroniser stages first. Carries ripple from the low byte to the middle byte to the high byte, and 0xFFFFFF wraps to 0x000000.
- R9: src_sel = 1 selects psu_tick and src_sel = 0 selects vsync_tick. Edges on the pin that is not selected have no effect.
- R10: After a clear, a single tick on the selected pin makes the low byte read non-zero, so software can tell that the tick source is alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Tick source select: 1 for the power tick, 0 for vertical sync |
| psu_tick | input | 1 | Asynchronous power-supply tick |
| vsync_tick | input | 1 | Asynchronous vertical-sync pulse |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 for a write, 0 for a read, qualified by cs |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
The hardest state to reach is a snapshot left held across a full clear-and-restart. Software only gets there through an unbalanced access order: a read of the high byte that is never followed by a read of the low byte, then the clear writes, then a tick. The bench builds this case directly. It reproduces the write-read-write-read-write clear order and then pulses the tick, so a stale low byte must appear before the release. Seeded random sequences of reads, loads and ticks then leave snapshots and halts open in many combinations, and a bench model follows them.

// File: rtl/tod_pkg.sv
package tod_pkg;
  parameter int TOD_BYTE_W      = 8;
  parameter int TOD_NBYTES      = 3;
  parameter int TOD_ADDR_W      = 2;
  parameter int TOD_SYNC_STAGES = 2;
  localparam int TOD_COUNT_W    = TOD_BYTE_W * TOD_NBYTES;
  localparam int TOD_IDX_LOW    = 0;
  localparam int TOD_IDX_HIGH   = TOD_NBYTES - 1;
endpackage

// File: rtl/tod_tick_sync.sv
module tod_tick_sync #(
  parameter int SYNC_STAGES = tod_pkg::TOD_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic psu_tick,
  input  logic vsync_tick,
  output logic tick_edge
);
  logic                   raw_tick;
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  assign raw_tick = src_sel ? psu_tick : vsync_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], raw_tick};
      prev  <= chain[SYNC_STAGES-1];
    end
  end

  assign tick_edge = chain[SYNC_STAGES-1] & ~prev;
endmodule

// File: rtl/tod_count_core.sv
module tod_count_core #(
  parameter int BYTE_W = tod_pkg::TOD_BYTE_W,
  parameter int NBYTES = tod_pkg::TOD_NBYTES,
  parameter int ADDR_W = tod_pkg::TOD_ADDR_W,
  localparam int CW    = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_edge,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CW-1:0]     count,
  output logic              halted
);
  logic [CW-1:0] count_nxt;
  logic          halted_nxt;
  logic [NBYTES-1:0] byte_hit;

  for (genvar b = 0; b < NBYTES; b++) begin : g_hit
    assign byte_hit[b] = wr_en && (wr_idx == ADDR_W'(b));
  end

  always_comb begin
    count_nxt  = count;
    halted_nxt = halted;
    if (wr_en) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (byte_hit[b]) count_nxt[b*BYTE_W +: BYTE_W] = wr_data;
      end
      if (byte_hit[NBYTES-1]) halted_nxt = 1'b1;
      if (byte_hit[0])        halted_nxt = 1'b0;
    end else if (tick_edge && !halted) begin
      count_nxt = count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      halted <= 1'b0;
    end else begin
      count  <= count_nxt;
      halted <= halted_nxt;
    end
  end
endmodule

// File: rtl/tod_read_latch.sv
module tod_read_latch #(
  parameter int BYTE_W = tod_pkg::TOD_BYTE_W,
  parameter int NBYTES = tod_pkg::TOD_NBYTES,
  parameter int ADDR_W = tod_pkg::TOD_ADDR_W,
  localparam int CW    = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_idx,
  input  logic [CW-1:0]     live_count,
  output logic              active,
  output logic [CW-1:0]     snap,
  output logic [BYTE_W-1:0] rd_data
);
  logic              rd_high;
  logic              rd_low;
  logic [CW-1:0]     src;
  logic [BYTE_W-1:0] src_bytes [NBYTES];

  assign rd_high = rd_en && (rd_idx == ADDR_W'(NBYTES-1));
  assign rd_low  = rd_en && (rd_idx == ADDR_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      snap   <= '0;
    end else if (!active && rd_high) begin
      active <= 1'b1;
      snap   <= live_count;
    end else if (active && rd_low) begin
      active <= 1'b0;
    end
  end

  assign src = active ? snap : live_count;

  for (genvar b = 0; b < NBYTES; b++) begin : g_split
    assign src_bytes[b] = src[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (rd_idx == ADDR_W'(b)) rd_data = src_bytes[b];
    end
  end
endmodule

// File: rtl/tod_event_counter.sv
module tod_event_counter #(
  parameter int BYTE_W      = tod_pkg::TOD_BYTE_W,
  parameter int NBYTES      = tod_pkg::TOD_NBYTES,
  parameter int ADDR_W      = tod_pkg::TOD_ADDR_W,
  parameter int SYNC_STAGES = tod_pkg::TOD_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic              psu_tick,
  input  logic              vsync_tick,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int CW = BYTE_W * NBYTES;

  logic          tick_edge;
  logic          wr_en;
  logic          rd_en;
  logic [CW-1:0] live_count;
  logic [CW-1:0] snap;
  logic          latch_active;
  logic          halted;

  assign wr_en = cs &  we;
  assign rd_en = cs & ~we;

  tod_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .psu_tick(psu_tick), .vsync_tick(vsync_tick), .tick_edge(tick_edge)
  );

  tod_count_core #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_edge(tick_edge), .wr_en(wr_en),
    .wr_idx(addr), .wr_data(wdata), .count(live_count), .halted(halted)
  );

  tod_read_latch #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(addr),
    .live_count(live_count), .active(latch_active), .snap(snap), .rd_data(rdata)
  );
endmodule

// File: rtl/tod_event_counter_chk.sv
module tod_event_counter_chk #(
  parameter int CW     = 24,
  parameter int ADDR_W = 2,
  parameter int NBYTES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [CW-1:0]     live_count,
  input logic [CW-1:0]     snap,
  input logic              latch_active,
  input logic              halted,
  input logic              tick_edge
);
  logic          wr_any;
  logic          rd_low;
  logic          rd_high;
  logic [CW-1:0] plus_one;

  assign wr_any   = cs && we;
  assign rd_low   = cs && !we && (addr == ADDR_W'(0));
  assign rd_high  = cs && !we && (addr == ADDR_W'(NBYTES-1));
  assign plus_one = live_count + CW'(1);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (live_count == '0 && !latch_active && !halted));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_active && rd_high) |=> (latch_active && snap == $past(live_count)));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_active && !rd_low) |=> (latch_active && $stable(snap)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_active && rd_low) |=> !latch_active);

  p_low_write_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_active && wr_any && addr == ADDR_W'(0)) |=> latch_active);

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_any) |=> $stable(live_count));

  p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_edge && !halted && !wr_any) |=> (live_count == $past(plus_one)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_edge && !wr_any) |=> $stable(live_count));
endmodule

bind tod_event_counter tod_event_counter_chk #(
  .CW(CW), .ADDR_W(ADDR_W), .NBYTES(NBYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
  .live_count(live_count), .snap(snap), .latch_active(latch_active),
  .halted(halted), .tick_edge(tick_edge)
);

// File: tb/tod_event_counter_tb.sv
module tod_event_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_sel = 1'b1;
  logic       psu_tick = 1'b0;
  logic       vsync_tick = 1'b0;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [23:0] m_cnt  = '0;
  logic [23:0] m_snap = '0;
  bit          m_act  = 1'b0;
  bit          m_halt = 1'b0;

  always #2 clk = ~clk;

  tod_event_counter u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .psu_tick(psu_tick),
    .vsync_tick(vsync_tick), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] byte_of(logic [23:0] v, int idx);
    if (idx > 2) return 8'h00;
    return v[idx*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 2'(idx); wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    if (idx <= 2) begin
      m_cnt[idx*8 +: 8] = d;
      if (idx == 2) m_halt = 1'b1;
      if (idx == 0) m_halt = 1'b0;
    end
  endtask

  task automatic bus_read(input int idx, input string req, output logic [7:0] got);
    logic [7:0] exp;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = 2'(idx);
    #1 got = rdata;
    exp = byte_of(m_act ? m_snap : m_cnt, idx);
    check(req, 24'(got), 24'(exp));
    if (idx == 2 && !m_act) begin m_act = 1'b1; m_snap = m_cnt; end
    else if (idx == 0 && m_act) m_act = 1'b0;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic read_all(input string req, output logic [23:0] v);
    logic [7:0] b2, b1, b0;
    bus_read(2, req, b2);
    bus_read(1, req, b1);
    bus_read(0, req, b0);
    v = {b2, b1, b0};
  endtask

  task automatic pulse(input bit on_psu);
    @(negedge clk);
    if (on_psu) psu_tick = 1'b1; else vsync_tick = 1'b1;
    repeat (5) @(negedge clk);
    psu_tick = 1'b0; vsync_tick = 1'b0;
    repeat (5) @(negedge clk);
    if ((on_psu == src_sel) && !m_halt) m_cnt = m_cnt + 24'd1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [7:0]  b;
    void'($urandom(32'd1234));
    repeat (8) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    read_all("R1", v);
    check("R1", v, 24'h000000);

    // R8, R9: power tick selected, vsync ignored
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    pulse(1'b0);
    read_all("R8", v);
    check("R9", v, 24'd3);
    src_sel = 1'b0;
    pulse(1'b0); pulse(1'b0);
    pulse(1'b1);
    read_all("R9", v);
    check("R9", v, 24'd5);

    // R3: snapshot holds through ticks
    bus_read(2, "R3", b);
    pulse(1'b0);
    bus_read(1, "R3", b);
    bus_read(0, "R3", b);
    check("R3", 24'(b), 24'd5);
    read_all("R3", v);
    check("R3", v, 24'd6);

    // R4, R6, R10: clear with interleaved reads, latch left held
    bus_read(2, "R4", b);
    bus_write(2, 8'h00);
    bus_read(2, "R4", b);
    bus_write(1, 8'h00);
    bus_read(1, "R4", b);
    bus_write(0, 8'h00);
    pulse(1'b0);
    bus_read(0, "R4", b);
    check("R4", 24'(b), 24'd6);
    read_all("R10", v);
    check("R10", 24'(v[7:0] != 8'h00), 24'd1);
    check("R6", v, 24'd1);

    // R5: low write keeps snapshot
    bus_read(2, "R5", b);
    bus_write(0, 8'h55);
    bus_read(1, "R5", b);
    bus_read(0, "R5", b);
    check("R5", 24'(b), 24'h01);
    read_all("R5", v);
    check("R5", v, 24'h000055);

    // R7: high write halts until low write
    bus_write(2, 8'h12);
    pulse(1'b0); pulse(1'b0);
    bus_write(1, 8'h34);
    bus_write(0, 8'h56);
    read_all("R7", v);
    check("R7", v, 24'h123456);
    pulse(1'b0);
    read_all("R7", v);
    check("R7", v, 24'h123457);

    // R8: carry and wrap
    bus_write(2, 8'h00); bus_write(1, 8'h00); bus_write(0, 8'hFF);
    pulse(1'b0);
    read_all("R8", v);
    check("R8", v, 24'h000100);
    bus_write(2, 8'hFF); bus_write(1, 8'hFF); bus_write(0, 8'hFF);
    pulse(1'b0);
    read_all("R8", v);
    check("R8", v, 24'h000000);

    // R2: index 3 inert
    bus_write(3, 8'hAA);
    bus_read(3, "R2", b);
    check("R2", 24'(b), 24'h00);
    read_all("R2", v);
    check("R2", v, 24'h000000);

    // Random mix; model tracks snapshot and halt
    for (int i = 0; i < 400; i++) begin
      int kind;
      int idx;
      logic [7:0] d;
      kind = int'($urandom_range(0, 9));
      idx  = int'($urandom_range(0, 3));
      case ($urandom_range(0, 2))
        0: d = 8'h00;
        1: d = 8'hFF;
        default: d = 8'($urandom);
      endcase
      if (kind < 4)      bus_read(idx, "R3", b);
      else if (kind < 6) bus_write(idx, d);
      else if (kind < 9) pulse(src_sel);
      else               pulse(!src_sel);
    end
    if (m_act) bus_read(0, "R4", b);
    bus_write(0, 8'h00);
    read_all("R6", v);
    check("R6", v, m_cnt);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule